// File: doc/BRIEF.md
# Branch Sample Record Buffer

This block captures the source and target addresses of retired taken branches into a small register file. It fills that file in a single pass. Software arms it by setting an enable bit in a configuration word. Each cycle in which the branch-retire strobe is high while recording is armed stores one source/target pair at the next-write index, and the index then advances. When the last entry has been written, the index returns to zero and the block clears its own enable bit. Older entries are therefore never overwritten.

A performance-counter overflow that arrives while recording is armed is not raised at once. It is held until capture ends, either because the buffer filled or because software cleared the enable bit. This keeps the sampling interrupt close to the recorded window. Software reads and writes the configuration word and every entry register through one register port. That port also lets software place a marker value in any target register, which the buffer stores like ordinary data.

The block does no filtering by branch type or privilege level. It does no address sign extension. The counter itself is outside the block and appears only as a single-cycle overflow input.

Top module: `bsr_capture`

## Requirements
- R1: With the default parameters the buffer holds 16 entries, each with a 64-bit source register and a 64-bit target register. The source of entry i sits at register address 2*i, its target at 2*i+1, and the configuration word at address 32. Any other address reads as zero.
- R2: `reg_rdata` is a combinational function of `reg_addr` and the stored state. After a register write, the new value is readable in the cycle that follows the write edge.
- R3: Configuration word fields: bit 2 is the recording enable, bit 5 the valid flag, bits 19:16 the next-write index, and bits 26:24 a counter-select field that reads back as written. Bits 4:3 always read 11b whatever was written. All other bits read 0.
- R4: A strobe cycle with recording enabled stores `br_src` and `br_dst` in the entry at the next-write index, and the index increases by one.
- R5: Capturing into entry 15 returns the index to 0 and clears the enable bit. Later strobes record nothing until software sets the enable bit again.
- R6: The valid flag becomes 1 on the first capture and stays 1 until a configuration write loads it with 0.
- R7: A configuration write loads the enable, valid, index and counter-select fields from the written word, so writing 0 clears them all. The reset state reads as 0x18.
- R8: An overflow pulse while recording is disabled produces a one-cycle `irq_out` pulse on the next cycle. An overflow while recording is enabled produces no pulse and is held.
- R9: When the enable bit falls, whether through fill or a software write, a held or same-cycle overflow is delivered as a one-cycle `irq_out` pulse on the next cycle, and the hold is dropped.
- R10: Software writes store any 64-bit value in an entry register, including 0xFFFFFFFFFFFFFFFE. When software writes the register that a capture targets in the same cycle, the software value wins.
- R11: Writing back the read configuration word with only bit 2 cleared stops recording and leaves the valid flag, the index and the entries unchanged.
- R12: A strobe in the same cycle as a configuration write is dropped. The index takes the written value and no entry changes.
- R13: Strobes while recording is disabled change neither the entries nor the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | Retired taken branch strobe |
| br_src | input | 64 | Branch source address |
| br_dst | input | 64 | Branch target address |
| ovf_in | input | 1 | Counter overflow pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| irq_out | output | 1 | Overflow interrupt pulse |

## Verification
Each register effect of a strobe or write edge (entry contents, index, valid flag, enable) can be read on the port one cycle after that edge. A read itself needs no clock. The interrupt pulse is due exactly one cycle after the edge that saw the overflow or the enable fall. The bench samples at the falling edge after each rising edge, compares `irq_out` and the read data of the currently addressed register against a behavioural model on every cycle, and so catches both a late and an early result. Reads sit on their own register address, and every write or strobe is followed by a readback taken one cycle later.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   // configuration word field positions (decoded by software)
   localparam int CFG_EN     = 2;
   localparam int CFG_FIX_LO = 3;
   localparam int CFG_VB     = 5;
   localparam int CFG_IDX_LO = 16;
   localparam int CFG_IDX_W  = 4;
   localparam int CFG_SEL_LO = 24;
   localparam int CFG_SEL_W  = 3;
   localparam int CFG_MIN_W  = CFG_SEL_LO + CFG_SEL_W;
endpackage

// File: rtl/bsr_cfg_ctrl.sv
module bsr_cfg_ctrl
   import bsr_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic                 wr_en,
   input  logic                 wr_vb,
   input  logic [PTR_W-1:0]     wr_idx,
   input  logic [CFG_SEL_W-1:0] wr_sel,
   input  logic                 br_valid,
   output logic                 en_q,
   output logic                 vb_q,
   output logic [PTR_W-1:0]     idx_q,
   output logic [CFG_SEL_W-1:0] sel_q,
   output logic                 cap,
   output logic                 en_clear
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic last_cap;

   always_comb begin
      cap      = br_valid && en_q && !cfg_wr;
      last_cap = cap && (idx_q == LAST);
      en_clear = en_q && ((cfg_wr && !wr_en) || last_cap);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         vb_q  <= 1'b0;
         idx_q <= '0;
         sel_q <= '0;
      end else if (cfg_wr) begin
         en_q  <= wr_en;
         vb_q  <= wr_vb;
         idx_q <= wr_idx;
         sel_q <= wr_sel;
      end else if (cap) begin
         idx_q <= idx_q + PTR_W'(1);
         vb_q  <= 1'b1;
         if (last_cap) en_q <= 1'b0;
      end
   end
endmodule

// File: rtl/bsr_irq_hold.sv
module bsr_irq_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_in,
   input  logic en_q,
   input  logic en_clear,
   output logic held_q,
   output logic irq_q
);
   logic fire;

   always_comb fire = (ovf_in && !en_q) || (en_clear && (held_q || ovf_in));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q  <= fire;
         held_q <= en_clear ? 1'b0 : (held_q || (ovf_in && en_q));
      end
   end
endmodule

// File: rtl/bsr_entry_file.sv
module bsr_entry_file #(
   parameter int DEPTH         = 16,
   parameter int DATA_W        = 64,
   parameter bit RESET_ENTRIES = 1'b1,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int SLOT_W = PTR_W + 1,
   localparam int SLOTS  = 2 * DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [PTR_W-1:0]  cap_idx,
   input  logic [DATA_W-1:0] cap_src,
   input  logic [DATA_W-1:0] cap_dst,
   input  logic              sw_we,
   input  logic [SLOT_W-1:0] sw_slot,
   input  logic [DATA_W-1:0] sw_wdata,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot_w [SLOTS];

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      logic              sw_hit, hw_hit;
      logic [DATA_W-1:0] nxt, q;

      always_comb begin
         sw_hit = sw_we && (sw_slot == SLOT_W'(k));
         hw_hit = cap && (cap_idx == PTR_W'(k / 2));
         nxt    = sw_hit ? sw_wdata : (((k % 2) == 1) ? cap_dst : cap_src);
      end

      if (RESET_ENTRIES) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= '0;
            else if (sw_hit || hw_hit) q <= nxt;
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (sw_hit || hw_hit) q <= nxt;
         end
      end

      assign slot_w[k] = q;
   end

   assign rd_data = slot_w[rd_slot];
endmodule

// File: rtl/bsr_capture.sv
module bsr_capture
   import bsr_pkg::*;
#(
   parameter int DEPTH         = 16,
   parameter int DATA_W        = 64,
   parameter bit RESET_ENTRIES = 1'b1,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int ADDR_W = $clog2(2 * DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_valid,
   input  logic [DATA_W-1:0] br_src,
   input  logic [DATA_W-1:0] br_dst,
   input  logic              ovf_in,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);
   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(2 * DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bsr_capture: DEPTH must be a power of two of at least 2");
   end
   if (PTR_W > CFG_IDX_W) begin : g_bad_ptr
      $error("bsr_capture: DEPTH too large for the index field");
   end
   if (DATA_W < CFG_MIN_W) begin : g_bad_width
      $error("bsr_capture: DATA_W too narrow for the configuration word");
   end

   logic                 is_cfg, is_ent, cfg_wr, ent_wr;
   logic                 en_q, vb_q, cap, en_clear, held_q;
   logic [PTR_W-1:0]     idx_q;
   logic [CFG_SEL_W-1:0] sel_q;
   logic [DATA_W-1:0]    ent_rd, cfg_word;

   always_comb begin
      is_cfg = (reg_addr == CFG_ADDR);
      is_ent = !reg_addr[ADDR_W-1];
      cfg_wr = reg_we && is_cfg;
      ent_wr = reg_we && is_ent;
   end

   bsr_cfg_ctrl #(.DEPTH(DEPTH)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .wr_en    (reg_wdata[CFG_EN]),
      .wr_vb    (reg_wdata[CFG_VB]),
      .wr_idx   (reg_wdata[CFG_IDX_LO +: PTR_W]),
      .wr_sel   (reg_wdata[CFG_SEL_LO +: CFG_SEL_W]),
      .br_valid (br_valid),
      .en_q     (en_q),
      .vb_q     (vb_q),
      .idx_q    (idx_q),
      .sel_q    (sel_q),
      .cap      (cap),
      .en_clear (en_clear)
   );

   bsr_irq_hold u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf_in   (ovf_in),
      .en_q     (en_q),
      .en_clear (en_clear),
      .held_q   (held_q),
      .irq_q    (irq_out)
   );

   bsr_entry_file #(
      .DEPTH(DEPTH), .DATA_W(DATA_W), .RESET_ENTRIES(RESET_ENTRIES)
   ) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .cap_idx  (idx_q),
      .cap_src  (br_src),
      .cap_dst  (br_dst),
      .sw_we    (ent_wr),
      .sw_slot  (reg_addr[ADDR_W-2:0]),
      .sw_wdata (reg_wdata),
      .rd_slot  (reg_addr[ADDR_W-2:0]),
      .rd_data  (ent_rd)
   );

   always_comb begin
      cfg_word                            = '0;
      cfg_word[CFG_EN]                    = en_q;
      cfg_word[CFG_FIX_LO +: 2]           = 2'b11;
      cfg_word[CFG_VB]                    = vb_q;
      cfg_word[CFG_IDX_LO +: PTR_W]       = idx_q;
      cfg_word[CFG_SEL_LO +: CFG_SEL_W]   = sel_q;
      if (is_cfg)      reg_rdata = cfg_word;
      else if (is_ent) reg_rdata = ent_rd;
      else             reg_rdata = '0;
   end
endmodule

// File: rtl/bsr_capture_chk.sv
module bsr_capture_chk #(
   parameter int DEPTH  = 16,
   parameter int PTR_W  = 4,
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              br_valid,
   input logic              ovf_in,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [PTR_W-1:0]  wdata_idx,
   input logic [1:0]        rd_fix,
   input logic              irq_out,
   input logic              en_q,
   input logic              vb_q,
   input logic [PTR_W-1:0]  idx_q,
   input logic              held_q
);
   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(2 * DEPTH);
   localparam logic [PTR_W-1:0]  LAST     = PTR_W'(DEPTH - 1);

   logic cfg_wr, cap_c;
   always_comb begin
      cfg_wr = reg_we && (reg_addr == CFG_ADDR);
      cap_c  = br_valid && en_q && !cfg_wr;
   end

   a_r4_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
      cap_c |=> idx_q == $past(idx_q) + PTR_W'(1));

   a_r5_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_c && idx_q == LAST) |=> (!en_q && idx_q == '0));

   a_r6_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
      cap_c |=> vb_q);

   a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && br_valid) |=> idx_q == $past(wdata_idx));

   a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !cfg_wr) |=> $stable(idx_q));

   a_r8_no_irq_while_armed: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (!$past(en_q) || !en_q));

   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(en_q) && $past(held_q)) |-> irq_out);

   a_r3_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == CFG_ADDR) |-> rd_fix == 2'b11);
endmodule

bind bsr_capture bsr_capture_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .br_valid  (br_valid),
   .ovf_in    (ovf_in),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .wdata_idx (reg_wdata[16 +: PTR_W]),
   .rd_fix    (reg_rdata[4:3]),
   .irq_out   (irq_out),
   .en_q      (en_q),
   .vb_q      (vb_q),
   .idx_q     (idx_q),
   .held_q    (held_q)
);

// File: tb/bsr_capture_test.sv
module bsr_capture_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        t_bv = 1'b0, t_ovf = 1'b0, t_we = 1'b0;
   logic [63:0] t_bs = '0, t_bd = '0, t_wd = '0;
   logic [5:0]  t_addr = 6'd32;
   logic [63:0] rdata;
   logic        irq;

   int    total = 0, bad = 0;
   string cur_req = "R7";
   bit    done = 1'b0;

   // behavioural reference
   logic [63:0] m_src [16];
   logic [63:0] m_dst [16];
   bit          m_en, m_vb, m_held, m_irq;
   logic [3:0]  m_idx;
   logic [2:0]  m_sel;

   always #4 clk = ~clk;   // 125 MHz

   bsr_capture uut (
      .clk(clk), .rst_n(rst_n), .br_valid(t_bv), .br_src(t_bs), .br_dst(t_bd),
      .ovf_in(t_ovf), .reg_we(t_we), .reg_addr(t_addr), .reg_wdata(t_wd),
      .reg_rdata(rdata), .irq_out(irq)
   );

   function automatic logic [63:0] exp_cfg();
      logic [63:0] w = '0;
      w[2] = m_en; w[4:3] = 2'b11; w[5] = m_vb; w[19:16] = m_idx; w[26:24] = m_sel;
      return w;
   endfunction

   function automatic logic [63:0] exp_read(logic [5:0] a);
      if (a == 6'd32) return exp_cfg();
      if (a < 6'd32)  return a[0] ? m_dst[a[4:1]] : m_src[a[4:1]];
      return '0;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s addr=%0d actual=%h expected=%h", req, t_addr, act, exp);
      end
   endtask

   task automatic model_step();
      bit wr_cfg, cap, last, clr;
      wr_cfg = t_we && t_addr == 6'd32;
      cap    = t_bv && m_en && !wr_cfg;
      last   = cap && m_idx == 4'd15;
      clr    = m_en && ((wr_cfg && !t_wd[2]) || last);
      m_irq  = (t_ovf && !m_en) || (clr && (m_held || t_ovf));
      m_held = clr ? 1'b0 : (m_held || (t_ovf && m_en));
      if (cap) begin
         m_src[m_idx] = t_bs;
         m_dst[m_idx] = t_bd;
      end
      if (t_we && t_addr < 6'd32) begin
         if (t_addr[0]) m_dst[t_addr[4:1]] = t_wd;
         else           m_src[t_addr[4:1]] = t_wd;
      end
      if (wr_cfg) begin
         m_en = t_wd[2]; m_vb = t_wd[5]; m_idx = t_wd[19:16]; m_sel = t_wd[26:24];
      end else if (cap) begin
         m_idx = m_idx + 4'd1;
         m_vb  = 1'b1;
         if (last) m_en = 1'b0;
      end
   endtask

   // one clock: inputs already driven at the falling edge
   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      check({cur_req, " irq"}, {63'd0, irq}, {63'd0, m_irq});
      check({cur_req, " rd"}, rdata, exp_read(t_addr));
      t_bv = 1'b0; t_ovf = 1'b0; t_we = 1'b0;
   endtask

   task automatic wr(logic [5:0] a, logic [63:0] d);
      t_we = 1'b1; t_addr = a; t_wd = d;
      tick();
   endtask

   task automatic branch(logic [63:0] s, logic [63:0] d, bit ovf);
      t_bv = 1'b1; t_bs = s; t_bd = d; t_ovf = ovf;
      tick();
   endtask

   task automatic rd(string req, logic [5:0] a);
      t_addr = a;
      #1;
      check(req, rdata, exp_read(a));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) begin m_src[i] = '0; m_dst[i] = '0; end
      m_en = 0; m_vb = 0; m_held = 0; m_irq = 0; m_idx = '0; m_sel = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R7 reset state, R2 read with no clock
      rd("R7", 6'd32);
      check("R7 reset word", rdata, 64'h18);
      check("R8 idle irq", {63'd0, irq}, 64'd0);

      // R10 marker value and R1 pair offsets
      cur_req = "R10";
      wr(6'd7, 64'hFFFF_FFFF_FFFF_FFFE);
      rd("R10", 6'd7);
      cur_req = "R1";
      wr(6'd30, 64'h1111_2222_3333_4444);
      wr(6'd31, 64'h5555_6666_7777_8888);
      rd("R1", 6'd30); rd("R1", 6'd31); rd("R1", 6'd40);

      // R13 strobe while disabled
      cur_req = "R13";
      t_addr = 6'd0;
      branch(64'hAAAA, 64'hBBBB, 1'b0);
      rd("R13", 6'd0); rd("R13", 6'd32);

      // R8 overflow while disabled -> pulse next cycle
      cur_req = "R8";
      t_ovf = 1'b1; tick();
      tick();

      // R3/R4/R6 arm with counter select 5, capture with a held overflow
      cur_req = "R3";
      wr(6'd32, 64'h0500_0004);
      rd("R3", 6'd32);
      cur_req = "R4";
      for (int i = 0; i < 5; i++) begin
         t_addr = 6'd32;
         branch(64'h1000 + i, 64'h2000 + i, i == 2);
      end
      for (int i = 0; i < 10; i++) rd("R4", 6'(i));
      rd("R6", 6'd32);

      // R5 fill to saturation, held overflow released on fill (R9)
      cur_req = "R5";
      for (int i = 5; i < 16; i++) branch(64'h1000 + i, 64'h2000 + i, 1'b0);
      cur_req = "R9";
      tick();
      rd("R5", 6'd32);
      cur_req = "R5";
      for (int i = 0; i < 3; i++) branch(64'hDEAD, 64'hBEEF, 1'b0);
      rd("R5", 6'd0); rd("R5", 6'd31); rd("R5", 6'd32);

      // R7 clear, R10 software write wins over capture on the same register
      cur_req = "R7";
      wr(6'd32, 64'h0);
      rd("R7", 6'd32);
      wr(6'd32, 64'h4);
      cur_req = "R10";
      t_we = 1'b1; t_addr = 6'd1; t_wd = 64'hFFFF_FFFF_FFFF_FFFE;
      t_bv = 1'b1; t_bs = 64'h7700; t_bd = 64'h7711;
      tick();
      rd("R10", 6'd0); rd("R10", 6'd1);

      // R11 stop by read-modify-write, R9 release of a held overflow
      cur_req = "R11";
      branch(64'h3001, 64'h3002, 1'b1);
      branch(64'h3003, 64'h3004, 1'b0);
      t_addr = 6'd32; #1;
      begin
         logic [63:0] w;
         w = rdata & ~64'h4;
         cur_req = "R9";
         wr(6'd32, w);
         tick();
      end
      rd("R11", 6'd32); rd("R11", 6'd2); rd("R11", 6'd5);

      // R12 strobe dropped on a configuration write
      cur_req = "R12";
      t_bv = 1'b1; t_bs = 64'h9999; t_bd = 64'h8888;
      wr(6'd32, 64'h0007_0024);
      rd("R12", 6'd32); rd("R12", 6'd6);
      t_bv = 1'b1; t_bs = 64'h9998; t_bd = 64'h8887;
      wr(6'd32, 64'h0007_0020);
      rd("R12", 6'd32); rd("R12", 6'd14); rd("R12", 6'd15);

      // R3 fixed bits read 11b, reserved read 0; last-entry fill with overflow
      cur_req = "R3";
      wr(6'd32, 64'hFFFF_FFFF_FFFF_FFE7);
      rd("R3", 6'd32);
      check("R3 word", rdata, 64'h070F_003C);
      cur_req = "R9";
      t_addr = 6'd32;
      branch(64'h4444, 64'h5555, 1'b1);
      tick();
      rd("R5", 6'd30); rd("R5", 6'd31); rd("R5", 6'd32);

      finish_run();
   end
endmodule